// File: doc/BRIEF.md
# Edge-Triggered One-Shot Pulse Timer

The block is a 16-bit up-counter with one capture input and one pulse output. In one-shot mode, the selected transition on the capture input starts a pulse. The counter restarts from a fixed preset. A fixed marker value is written into the capture register. The output takes a programmed "during" level. When the running count reaches the value in the compare register, the output changes to a programmed "after" level and holds it until the next trigger.

Each trigger raises an event flag. This flag drives an interrupt request when interrupts are enabled. Software clears the flag in two steps. First it reads the status register while the flag is set. Then it reads or writes the low byte of the capture register.

The counter rate comes from a small prescaler. It divides the system clock by 2, 4 or 8, or it follows an external count-enable input. Control and compare values are loaded through a byte-wide register port with combinational read data.

Top module: `oneshot_timer`

## Requirements
- R1: The register port uses a 3-bit address, and reads are combinational.
  - Address 0 is control: bit0 is edge select (1 = rising), bit1 is the during level, bit2 is the after level, bit3 is output enable, bit4 is one-shot mode enable, bits 6:5 are clock select, and bit7 is interrupt enable.
  - Address 1 is status, with the event flag in bit7.
  - Addresses 2/3 are capture high/low, 4/5 are compare high/low, and 6/7 are counter high/low.
  - After reset, every register reads 0, and `pulse_o` and `irq_o` are 0.
- R2: Only the transition chosen by edge select triggers. The opposite transition has no effect.
- R3: A trigger loads the counter with 16'hFFFC, loads the capture register with 16'hFFFD, and sets the event flag.
- R4: A trigger sets the output to the during level. Once the counter equals the compare value, the output switches to the after level. With a count enable every cycle, the during level lasts ((compare − 16'hFFFC) mod 2^16) + 1 cycles.
- R5: With output enable clear, `pulse_o` stays 0.
- R6: `irq_o` is high exactly while the event flag and interrupt enable are both set.
- R7: The flag clears only on a capture-low read or write that follows a status read made while the flag was set. A capture-low access without that prior status read leaves the flag set.
- R8: Clock select codes 0, 1 and 2 advance the counter once every 2, 4 and 8 system clocks. Code 3 advances it on each cycle in which `ext_tick_i` is high.
- R9: A trigger during an active pulse restarts the counter and the pulse, so the during level lasts the full length again, measured from the new trigger.
- R10: With one-shot mode disabled, capture edges neither set the flag nor change the capture register.
- R11: A trigger that occurs between the status read and the capture-low access cancels the pending clear, so the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_i | input | 1 | Asynchronous capture (trigger) input |
| ext_tick_i | input | 1 | External count enable used with clock select code 3 |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effects only) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data |
| pulse_o | output | 1 | Pulse output |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: a 16-bit counter, a preset of 16'hFFFC, a capture marker of 16'hFFFD, a two-stage synchroniser and a 3-bit divider. Because the preset sits four counts below wrap-around, compare values on both sides of the 16'hFFFF-to-0 boundary are reached within a handful of cycles. Pulse lengths are measured in external-tick mode with the tick held high, so each one is an exact cycle count. The divided rates are checked by sampling the counter low byte 64 cycles apart, a multiple of every divisor.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  typedef struct packed {
    logic       irq_en;
    logic [1:0] clk_sel;
    logic       mode_en;
    logic       out_en;
    logic       lvl_after;
    logic       lvl_during;
    logic       rise_sel;
  } ctrl_t;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_CAPH = 3'd2;
  localparam logic [2:0] A_CAPL = 3'd3;
  localparam logic [2:0] A_CMPH = 3'd4;
  localparam logic [2:0] A_CMPL = 3'd5;
  localparam logic [2:0] A_CNTH = 3'd6;
  localparam logic [2:0] A_CNTL = 3'd7;

  localparam logic [1:0] CLK_EXT = 2'd3;

endpackage

// File: rtl/os_sync_edge.sv
module os_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  input  logic rise_sel_i,
  output logic edge_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              level;

  // Synchroniser chain, one flop per stage.
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  assign level = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  always_comb begin
    if (rise_sel_i) edge_o = level & ~prev_q;
    else            edge_o = ~level & prev_q;
  end

  // R2: a selected rising edge is a single-cycle event.
  p_single_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_o && rise_sel_i) |=> !(edge_o && rise_sel_i));

endmodule

// File: rtl/os_prescaler.sv
module os_prescaler #(
  parameter int DIV_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_i,
  input  logic       ext_tick_i,
  output logic       tick_o
);

  import oneshot_pkg::*;

  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] mask;

  always_comb begin
    div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // Codes 0..2 give a period of 2^(code+1).
  always_comb begin
    mask = '0;
    for (int b = 0; b < DIV_W; b++) begin
      if (b <= int'(sel_i)) mask[b] = 1'b1;
    end
    if (sel_i == CLK_EXT) tick_o = ext_tick_i;
    else                  tick_o = ((div_q & mask) == mask);
  end

  // R8: an internal rate never ticks on two back-to-back cycles.
  p_tick_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && sel_i != CLK_EXT) |=>
      (!tick_o || sel_i == CLK_EXT || sel_i != $past(sel_i)));

endmodule

// File: rtl/os_pulse_core.sv
module os_pulse_core #(
  parameter int               CNT_W     = 16,
  parameter logic [CNT_W-1:0] PRESET    = 16'hFFFC,
  parameter logic [CNT_W-1:0] CAP_FIXED = 16'hFFFD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             trig_i,
  input  logic             mode_en_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             lvl_during_i,
  input  logic             lvl_after_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap_o,
  output logic             out_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cap_q, cap_d;
  logic             out_q, out_d;
  logic             hit;

  assign hit = mode_en_i && (cnt_q == cmp_i);

  always_comb begin
    cnt_d = cnt_q;
    cap_d = cap_q;
    out_d = out_q;
    if (trig_i) begin
      cnt_d = PRESET;
      cap_d = CAP_FIXED;
      out_d = lvl_during_i;
    end else begin
      if (tick_i) cnt_d = cnt_q + 1'b1;
      if (hit)    out_d = lvl_after_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cap_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      cap_q <= cap_d;
      out_q <= out_d;
    end
  end

  assign cnt_o = cnt_q;
  assign cap_o = cap_q;
  assign out_o = out_q;

  p_preset_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> (cnt_q == PRESET && cap_q == CAP_FIXED));
  p_during_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> (out_q == $past(lvl_during_i)));
  p_after_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_i && mode_en_i && cnt_q == cmp_i) |=> (out_q == $past(lvl_after_i)));

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int               CNT_W       = 16,
  parameter logic [CNT_W-1:0] PRESET      = 16'hFFFC,
  parameter logic [CNT_W-1:0] CAP_FIXED   = 16'hFFFD,
  parameter int               SYNC_STAGES = 2,
  parameter int               DIV_W       = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_i,
  input  logic       ext_tick_i,
  input  logic [2:0] addr_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       pulse_o,
  output logic       irq_o
);

  import oneshot_pkg::*;

  localparam int BYTE_W = 8;

  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             flag_q, flag_d;
  logic             armed_q, armed_d;
  logic             edge_s, trig, tick, out_lvl;
  logic             stat_rd, capl_acc;
  logic [CNT_W-1:0] cnt, cap;

  os_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .async_i(cap_i),
    .rise_sel_i(ctrl_q.rise_sel), .edge_o(edge_s)
  );

  os_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .sel_i(ctrl_q.clk_sel),
    .ext_tick_i(ext_tick_i), .tick_o(tick)
  );

  assign trig = edge_s & ctrl_q.mode_en;

  os_pulse_core #(.CNT_W(CNT_W), .PRESET(PRESET), .CAP_FIXED(CAP_FIXED)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .trig_i(trig),
    .mode_en_i(ctrl_q.mode_en), .cmp_i(cmp_q),
    .lvl_during_i(ctrl_q.lvl_during), .lvl_after_i(ctrl_q.lvl_after),
    .cnt_o(cnt), .cap_o(cap), .out_o(out_lvl)
  );

  assign stat_rd  = rd_en_i && (addr_i == A_STAT);
  assign capl_acc = (rd_en_i || wr_en_i) && (addr_i == A_CAPL);

  always_comb begin
    ctrl_d  = ctrl_q;
    cmp_d   = cmp_q;
    flag_d  = flag_q;
    armed_d = armed_q;
    if (wr_en_i) begin
      case (addr_i)
        A_CTRL:  ctrl_d = ctrl_t'(wdata_i);
        A_CMPH:  cmp_d[CNT_W-1 -: BYTE_W] = wdata_i;
        A_CMPL:  cmp_d[BYTE_W-1:0] = wdata_i;
        default: ;
      endcase
    end
    if (trig) begin
      flag_d  = 1'b1;
      armed_d = 1'b0;
    end else if (armed_q && capl_acc) begin
      flag_d  = 1'b0;
      armed_d = 1'b0;
    end else if (stat_rd && flag_q) begin
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cmp_q   <= '0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      cmp_q   <= cmp_d;
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = ctrl_q;
      A_STAT:  rdata_o = {flag_q, 7'b0};
      A_CAPH:  rdata_o = cap[CNT_W-1 -: BYTE_W];
      A_CAPL:  rdata_o = cap[BYTE_W-1:0];
      A_CMPH:  rdata_o = cmp_q[CNT_W-1 -: BYTE_W];
      A_CMPL:  rdata_o = cmp_q[BYTE_W-1:0];
      A_CNTH:  rdata_o = cnt[CNT_W-1 -: BYTE_W];
      default: rdata_o = cnt[BYTE_W-1:0];
    endcase
  end

  assign pulse_o = ctrl_q.out_en & out_lvl;
  assign irq_o   = ctrl_q.irq_en & flag_q;

  // R7: the flag only falls on an armed capture-low access.
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(armed_q && capl_acc));
  // R10: the flag only rises while one-shot mode is on.
  p_flag_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(ctrl_q.mode_en));
  // R11: a trigger leaves no pending clear behind.
  p_trig_disarm_r11: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (flag_q && !armed_q));

endmodule

// File: tb/oneshot_timer_test.sv
`timescale 1ns/1ps
module oneshot_timer_test;

  logic       clk, rst_n, cap_i, ext_tick_i, wr_en_i, rd_en_i;
  logic [2:0] addr_i;
  logic [7:0] wdata_i, rdata_o;
  logic       pulse_o, irq_o;
  int         checks = 0, fails = 0;

  oneshot_timer uut (
    .clk(clk), .rst_n(rst_n), .cap_i(cap_i), .ext_tick_i(ext_tick_i),
    .addr_i(addr_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pulse_o(pulse_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic        rise;
    logic        during;
    logic        after;
    logic [15:0] cmp;
    logic [31:0] width;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b1, 1'b1, 1'b0, 16'h0002, 32'd7},
    '{1'b0, 1'b1, 1'b0, 16'hFFFC, 32'd1},
    '{1'b1, 1'b0, 1'b1, 16'h0010, 32'd21},
    '{1'b0, 1'b0, 1'b1, 16'hFFFF, 32'd4},
    '{1'b1, 1'b1, 1'b0, 16'h0000, 32'd5}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ctl(bit irq, logic [1:0] cs, bit mode, bit oe,
                                     bit after, bit during, bit rise);
    return {irq, cs, mode, oe, after, during, rise};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr_i = a; rd_en_i = 1'b1;
    #1 d = rdata_o;
    @(posedge clk); @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    addr_i = a; #1 d = rdata_o;
  endtask

  task automatic drive_cap(input logic lvl);
    cap_i = lvl;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic measure(input logic lvl, output int n);
    n = 0;
    while (pulse_o == lvl && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic clear_flag();
    logic [7:0] d;
    rd(3'd1, d);
    rd(3'd3, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d, a, b;
    int n;
    rst_n = 1'b0; cap_i = 1'b0; ext_tick_i = 1'b0;
    addr_i = '0; wr_en_i = 1'b0; rd_en_i = 1'b0; wdata_i = '0;
    repeat (3) @(negedge clk);
    #1;
    check(pulse_o == 1'b0 && irq_o == 1'b0, "R1 reset outputs", {pulse_o, irq_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      peek(3'(i), d);
      check(d == 8'h00, "R1 reset register", d, 0);
    end

    // R8: counter rate per clock-select code
    for (int c = 0; c < 4; c++) begin
      ext_tick_i = 1'b1;
      wr(3'd0, ctl(0, 2'(c), 0, 0, 0, 0, 1));
      peek(3'd7, a);
      repeat (64) @(negedge clk);
      peek(3'd7, b);
      check(8'(b - a) == 8'(64 >> (c < 3 ? c + 1 : 0)), "R8 counter rate",
            8'(b - a), 8'(64 >> (c < 3 ? c + 1 : 0)));
    end
    ext_tick_i = 1'b0;
    wr(3'd0, ctl(0, 2'd3, 0, 0, 0, 0, 1));
    peek(3'd7, a);
    repeat (20) @(negedge clk);
    peek(3'd7, b);
    check(a == b, "R8 external enable low holds count", b, a);

    // Main function: table of pulse vectors
    ext_tick_i = 1'b1;
    foreach (VECS[i]) begin
      wr(3'd0, ctl(1, 2'd3, 0, 1, VECS[i].after, VECS[i].during, VECS[i].rise));
      wr(3'd4, VECS[i].cmp[15:8]);
      wr(3'd5, VECS[i].cmp[7:0]);
      drive_cap(~VECS[i].rise);
      wr(3'd0, ctl(1, 2'd3, 1, 1, VECS[i].after, VECS[i].during, VECS[i].rise));
      drive_cap(VECS[i].rise);
      check(pulse_o == VECS[i].during, "R4 during level", pulse_o, VECS[i].during);
      check(irq_o == 1'b1, "R6 irq on trigger", irq_o, 1);
      measure(VECS[i].during, n);
      check(n == int'(VECS[i].width), "R4 pulse width", n, VECS[i].width);
      check(pulse_o == VECS[i].after, "R4 after level", pulse_o, VECS[i].after);
      clear_flag();
      check(irq_o == 1'b0, "R7 flag cleared by sequence", irq_o, 0);
    end

    // R3: preset and capture marker (counter frozen)
    ext_tick_i = 1'b0;
    wr(3'd0, ctl(1, 2'd3, 1, 1, 0, 1, 1));
    drive_cap(1'b0);
    drive_cap(1'b1);
    peek(3'd6, a); peek(3'd7, b);
    check({a, b} == 16'hFFFC, "R3 counter preset", {a, b}, 16'hFFFC);
    peek(3'd2, a); peek(3'd3, b);
    check({a, b} == 16'hFFFD, "R3 capture value", {a, b}, 16'hFFFD);

    // R7: capture-low access without status read keeps the flag
    rd(3'd3, d);
    check(irq_o == 1'b1, "R7 no clear without status read", irq_o, 1);
    rd(3'd1, d);
    check(d[7] == 1'b1, "R7 status shows flag", d, 8'h80);
    wr(3'd3, 8'h55);
    check(irq_o == 1'b0, "R7 clear by capture-low write", irq_o, 0);

    // R11: a trigger between the two steps cancels the clear
    drive_cap(1'b0);
    drive_cap(1'b1);
    rd(3'd1, d);
    drive_cap(1'b0);
    drive_cap(1'b1);
    rd(3'd3, d);
    check(irq_o == 1'b1, "R11 trigger cancels pending clear", irq_o, 1);
    clear_flag();

    // R6: interrupt enable gates the request
    drive_cap(1'b0);
    drive_cap(1'b1);
    wr(3'd0, ctl(0, 2'd3, 1, 1, 0, 1, 1));
    check(irq_o == 1'b0, "R6 irq masked", irq_o, 0);
    wr(3'd0, ctl(1, 2'd3, 1, 1, 0, 1, 1));
    check(irq_o == 1'b1, "R6 irq unmasked", irq_o, 1);
    clear_flag();

    // R2: opposite edge is ignored
    wr(3'd0, ctl(1, 2'd3, 1, 1, 0, 1, 0));
    drive_cap(1'b0);
    clear_flag();
    drive_cap(1'b1);
    check(irq_o == 1'b0, "R2 rising ignored when falling selected", irq_o, 0);
    drive_cap(1'b0);
    check(irq_o == 1'b1, "R2 falling edge triggers", irq_o, 1);
    clear_flag();

    // R10: mode disabled ignores edges
    wr(3'd0, ctl(1, 2'd3, 0, 1, 0, 1, 1));
    wr(3'd4, 8'h12);
    drive_cap(1'b1);
    peek(3'd3, d);
    check(irq_o == 1'b0 && d == 8'hFD, "R10 edge ignored with mode off", {irq_o, d}, 8'hFD);

    // R5: output enable clear keeps the pin low
    wr(3'd0, ctl(1, 2'd3, 1, 0, 0, 1, 1));
    wr(3'd4, 8'h00); wr(3'd5, 8'h10);
    drive_cap(1'b0);
    drive_cap(1'b1);
    check(pulse_o == 1'b0, "R5 output gated off", pulse_o, 0);
    clear_flag();

    // R9: retrigger restarts the pulse
    ext_tick_i = 1'b1;
    wr(3'd0, ctl(1, 2'd3, 1, 1, 0, 1, 1));
    drive_cap(1'b0);
    drive_cap(1'b1);
    cap_i = 1'b0;
    repeat (8) @(negedge clk);
    check(pulse_o == 1'b1, "R9 still in first pulse", pulse_o, 1);
    drive_cap(1'b1);
    measure(1'b1, n);
    check(n == 21, "R9 width from retrigger", n, 21);
    clear_flag();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule